// File: doc/BRIEF.md
# Radio SPI Command Decoder

This block sits behind the byte-level SPI shifter of a packet radio and turns each received byte into an action. The first byte of a chip-select window is a command. Depending on its flag bits and address field, the command does one of five things:

- fires a one-byte command strobe toward the radio controller;
- opens a two-byte register read or write;
- opens an endless stream into the transmit buffer;
- opens an endless stream out of the receive buffer;
- opens byte-wise access to the internal RAM.

For every byte taken in, the block registers the byte to return on the next transfer. That byte is the radio status, the old register contents, receive-buffer data or RAM data, depending on the access.

The register file, buffers and RAM live outside the block. The decoder drives their address, data and write or pop strobes, and reads their current contents combinationally. A supply-ready input stops all activity while the radio core is unpowered. Dropping chip-select always ends the access in progress.

Top module: `radio_cmd_decoder`

## Requirements
- R1: A command byte below 0x0F pulses `strobe_valid` for one cycle with `strobe_code` equal to the byte, and the next byte is decoded as a new command.
- R2: A command with bit 7 = 0 and bit 6 = 0 whose address (bits 5:0) is 0x0F to 0x3D writes that register over two bytes, high byte first. The reply is the old high byte and then the old low byte. The decoder then returns to command decoding.
- R3: A command with bit 7 = 0 and bit 6 = 1 (address not 0x3E/0x3F) returns the register's high byte and then its low byte, with no write. The decoder then returns to command decoding.
- R4: If chip-select drops after only the high data byte of a register write, the register holds the new high byte and its old low byte.
- R5: Address 0x3E (command 0x3E or 0x7E) opens a transmit-buffer stream: each following byte is written at the buffer write index, which then advances by one.
- R6: The transmit write index wraps from 127 to 0. After a `tx_done` pulse, the next transmit-buffer write goes to index 0.
- R7: Address 0x3F (command 0x3F or 0x7F) opens a receive-buffer stream: each following byte returns the buffer head and pops it once.
- R8: A command with bit 7 = 1 opens RAM access. Its bits 6:0 are RAM address bits 6:0. In the second byte, bits 7:6 are address bits 8:7, and bit 5 = 1 selects read, 0 selects write.
- R9: The RAM address advances by one after each data byte, and becomes 0 when it would reach 0x180.
- R10: A RAM write stores each data byte at the current address. A RAM read returns the byte at the current address.
- R11: The reply byte appears on `miso_byte` in the cycle after the byte is taken. It is the status input for the command byte, transmit-buffer data bytes, the RAM address byte and RAM write data bytes. It is 0x00 after reset.
- R12: While chip-select is low, the decoder is back in command decoding one cycle later, so the first byte of the next window is a command.
- R13: While `supply_ok` is low, every reply is 0x00 and no strobe, register write, buffer write, pop or RAM write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel | input | 1 | Chip-select, high while selected |
| supply_ok | input | 1 | Radio core powered and ready |
| rx_valid | input | 1 | One-cycle pulse: a byte arrived from the shifter |
| rx_byte | input | 8 | Received byte |
| miso_byte | output | 8 | Byte to shift out on the next transfer |
| status_in | input | 8 | Current radio status byte |
| strobe_valid | output | 1 | Command strobe pulse |
| strobe_code | output | 4 | Strobe number |
| reg_addr | output | 6 | Register file address |
| reg_rdata | input | 16 | Register contents at `reg_addr` |
| reg_we | output | 1 | Register write enable |
| reg_wdata | output | 16 | Register write data |
| txb_we | output | 1 | Transmit-buffer write enable |
| txb_idx | output | 7 | Transmit-buffer write index |
| txb_wdata | output | 8 | Transmit-buffer write data |
| tx_done | input | 1 | Pulse when a transmission completes |
| rxb_pop | output | 1 | Receive-buffer pop |
| rxb_rdata | input | 8 | Receive-buffer head byte |
| ram_addr | output | 9 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM contents at `ram_addr` |

## Verification
A wrong decoder state shows up on the very next transfer. Either the reply byte is status where register or buffer data was due (or the other way round), or a strobe, write or pop fires on a byte that should have been data. A corrupted address or index is seen one byte later, when data lands in the wrong register, RAM cell or buffer slot, or a read returns the wrong cell. A missed return to command decoding after a chip-select drop appears on the first byte of the following window.

// File: rtl/radio_cmd_decoder.sv
module radio_cmd_decoder #(
  parameter int RAM_AW   = 9,
  parameter int RAM_TOP  = 384,
  parameter int TXB_AW   = 7,
  parameter int REG_AW   = 6,
  parameter int STROBE_LIM = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel,
  input  logic              supply_ok,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        miso_byte,
  input  logic [7:0]        status_in,
  output logic              strobe_valid,
  output logic [3:0]        strobe_code,
  output logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_rdata,
  output logic              reg_we,
  output logic [15:0]       reg_wdata,
  output logic              txb_we,
  output logic [TXB_AW-1:0] txb_idx,
  output logic [7:0]        txb_wdata,
  input  logic              tx_done,
  output logic              rxb_pop,
  input  logic [7:0]        rxb_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  localparam int LO_W = RAM_AW - 2;
  localparam logic [REG_AW-1:0] TXB_REG = REG_AW'(62);
  localparam logic [REG_AW-1:0] RXB_REG = REG_AW'(63);

  typedef enum logic [3:0] {
    S_CMD, S_WHI, S_WLO, S_RHI, S_RLO, S_TXW, S_RXR, S_RAMA, S_RAMW, S_RAMR
  } st_t;

  st_t st, st_nx;
  logic [RAM_AW-1:0] ptr, ptr_nx, ram_next;
  logic [7:0] hi_keep, resp;
  logic [TXB_AW-1:0] tx_ptr;
  logic tx_fresh, take;

  assign take         = rx_valid & spi_sel & supply_ok;
  assign strobe_valid = take && st == S_CMD && rx_byte < 8'(STROBE_LIM);
  assign strobe_code  = rx_byte[3:0];

  assign reg_addr  = ptr[REG_AW-1:0];
  assign reg_we    = take && (st == S_WHI || st == S_WLO);
  assign reg_wdata = (st == S_WHI) ? {rx_byte, reg_rdata[7:0]} : {hi_keep, rx_byte};

  assign txb_we    = take && st == S_TXW;
  assign txb_idx   = tx_fresh ? '0 : tx_ptr;
  assign txb_wdata = rx_byte;

  assign rxb_pop   = take && st == S_RXR;

  assign ram_addr  = ptr;
  assign ram_we    = take && st == S_RAMW;
  assign ram_wdata = rx_byte;
  assign ram_next  = (int'(ptr) + 1 >= RAM_TOP) ? '0 : ptr + 1'b1;

  always_comb begin
    st_nx  = st;
    ptr_nx = ptr;
    case (st)
      S_CMD: begin
        if (rx_byte[7]) begin
          st_nx  = S_RAMA;
          ptr_nx = RAM_AW'(rx_byte[6:0]);
        end else begin
          ptr_nx = RAM_AW'(rx_byte[REG_AW-1:0]);
          if (rx_byte[REG_AW-1:0] == TXB_REG)      st_nx = S_TXW;
          else if (rx_byte[REG_AW-1:0] == RXB_REG) st_nx = S_RXR;
          else if (rx_byte < 8'(STROBE_LIM))       st_nx = S_CMD;
          else if (rx_byte[6])                     st_nx = S_RHI;
          else                                     st_nx = S_WHI;
        end
      end
      S_WHI:  st_nx = S_WLO;
      S_WLO:  st_nx = S_CMD;
      S_RHI:  st_nx = S_RLO;
      S_RLO:  st_nx = S_CMD;
      S_RAMA: begin
        ptr_nx = {rx_byte[7:6], ptr[LO_W-1:0]};
        st_nx  = rx_byte[5] ? S_RAMR : S_RAMW;
      end
      S_RAMW, S_RAMR: ptr_nx = ram_next;
      default: st_nx = st;
    endcase
  end

  always_comb begin
    case (st)
      S_WHI, S_RHI: resp = reg_rdata[15:8];
      S_WLO, S_RLO: resp = reg_rdata[7:0];
      S_RXR:        resp = rxb_rdata;
      S_RAMR:       resp = ram_rdata;
      default:      resp = status_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_CMD;
      ptr       <= '0;
      hi_keep   <= '0;
      tx_ptr    <= '0;
      tx_fresh  <= 1'b0;
      miso_byte <= '0;
    end else begin
      if (!spi_sel || !supply_ok) st <= S_CMD;
      else if (rx_valid) begin
        st  <= st_nx;
        ptr <= ptr_nx;
      end
      if (rx_valid && spi_sel) miso_byte <= supply_ok ? resp : 8'h00;
      if (take && st == S_WHI) hi_keep <= rx_byte;
      if (txb_we) begin
        tx_ptr   <= txb_idx + 1'b1;
        tx_fresh <= 1'b0;
      end
      if (tx_done) tx_fresh <= 1'b1;
    end
  end

  a_r12_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sel |=> st == S_CMD);

  a_r13_quiet_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !(strobe_valid || reg_we || txb_we || rxb_pop || ram_we));

  a_r13_zero_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && spi_sel && !supply_ok |=> miso_byte == 8'h00);

  a_r2_write_ends: assert property (@(posedge clk) disable iff (!rst_n)
    take && st == S_WLO |=> st == S_CMD);

  a_r1_strobe_stays: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid |=> st == S_CMD);

  a_r9_ram_step: assert property (@(posedge clk) disable iff (!rst_n)
    take && (st == S_RAMW || st == S_RAMR) |=>
      (ram_addr == '0 || int'(ram_addr) == int'($past(ram_addr)) + 1));

  a_r6_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    txb_we && !tx_done |=> txb_idx == TXB_AW'($past(txb_idx) + 1'b1));

endmodule

// File: tb/test_radio_cmd_decoder.sv
module test_radio_cmd_decoder;
  localparam int CLK_NS = 10;
  localparam int NV = 36;
  localparam logic [7:0] STAT = 8'h46;

  logic clk = 1'b0, rst_n = 1'b0, spi_sel = 1'b0, supply_ok = 1'b1;
  logic rx_valid = 1'b0, tx_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] miso_byte, txb_wdata, ram_wdata, rxb_rdata, ram_rdata;
  logic strobe_valid, reg_we, txb_we, rxb_pop, ram_we;
  logic [3:0] strobe_code;
  logic [5:0] reg_addr;
  logic [15:0] reg_rdata, reg_wdata;
  logic [6:0] txb_idx;
  logic [8:0] ram_addr;

  logic [15:0] reg_mem [64];
  logic [7:0]  ram_mem [512];
  logic [7:0]  tx_mem  [128];
  int rx_pops, strobe_cnt, last_code;
  int n_total = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign reg_rdata = reg_mem[reg_addr];
  assign ram_rdata = ram_mem[ram_addr];
  assign rxb_rdata = 8'hC0 + 8'(rx_pops);

  radio_cmd_decoder i_radio_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .supply_ok(supply_ok),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .miso_byte(miso_byte),
    .status_in(STAT), .strobe_valid(strobe_valid), .strobe_code(strobe_code),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .txb_we(txb_we), .txb_idx(txb_idx), .txb_wdata(txb_wdata), .tx_done(tx_done),
    .rxb_pop(rxb_pop), .rxb_rdata(rxb_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) reg_mem[i] <= {2'b01, 6'(i), 2'b10, 6'(i)};
      for (int i = 0; i < 512; i++) ram_mem[i] <= 8'(i) ^ 8'h3C;
      for (int i = 0; i < 128; i++) tx_mem[i] <= 8'h00;
      rx_pops <= 0; strobe_cnt <= 0; last_code <= -1;
    end else begin
      if (reg_we) reg_mem[reg_addr] <= reg_wdata;
      if (ram_we) ram_mem[ram_addr] <= ram_wdata;
      if (txb_we) tx_mem[txb_idx] <= txb_wdata;
      if (rxb_pop) rx_pops <= rx_pops + 1;
      if (strobe_valid) begin strobe_cnt <= strobe_cnt + 1; last_code <= int'(strobe_code); end
    end
  end

  // {deselect first, byte sent, expected reply}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,8'h03,8'h46}, {1'b0,8'h0E,8'h46},                       // R1
    {1'b1,8'h52,8'h46}, {1'b0,8'h00,8'h52}, {1'b0,8'h00,8'h92},    // R3
    {1'b0,8'h05,8'h46},                                            // R1 after R3
    {1'b1,8'h14,8'h46}, {1'b0,8'hAB,8'h54}, {1'b0,8'hCD,8'h94},    // R2
    {1'b1,8'h54,8'h46}, {1'b0,8'h00,8'hAB}, {1'b0,8'h00,8'hCD},    // R2 readback
    {1'b1,8'h3F,8'h46}, {1'b0,8'h00,8'hC0}, {1'b0,8'h00,8'hC1},    // R7
    {1'b1,8'h7F,8'h46}, {1'b0,8'h00,8'hC2},                        // R7
    {1'b1,8'h3E,8'h46}, {1'b0,8'h11,8'h46}, {1'b0,8'h22,8'h46},    // R5 R11
    {1'b1,8'hFF,8'h46}, {1'b0,8'hA0,8'h46}, {1'b0,8'h00,8'h43},    // R8
    {1'b0,8'h00,8'h3C}, {1'b0,8'h00,8'h3D},                        // R9
    {1'b1,8'h85,8'h46}, {1'b0,8'h00,8'h46}, {1'b0,8'h99,8'h46},    // R10
    {1'b0,8'h98,8'h46},
    {1'b1,8'h85,8'h46}, {1'b0,8'h20,8'h46}, {1'b0,8'h00,8'h99},    // R10
    {1'b0,8'h00,8'h98},
    {1'b1,8'h80,8'h46}, {1'b0,8'h60,8'h46}, {1'b0,8'h00,8'hBC}     // R8
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic [7:0] got);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0; got = miso_byte;
  endtask

  task automatic deselect();
    @(negedge clk); spi_sel = 1'b0;
    @(negedge clk);
    @(negedge clk); spi_sel = 1'b1;
  endtask

  task automatic expect_reply(input logic [7:0] b, input logic [7:0] exp, input string req);
    logic [7:0] got;
    send(b, got);
    check(got == exp, req, int'(got), int'(exp));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(miso_byte == 8'h00, "R11 reset reply", int'(miso_byte), 0);
    check(!(strobe_valid | reg_we | txb_we | rxb_pop | ram_we), "R11 reset idle", 1, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][16]) deselect();
      expect_reply(VEC[k][15:8], VEC[k][7:0], $sformatf("R1-table entry %0d", k));
    end
    check(strobe_cnt == 3, "R1 strobe count", strobe_cnt, 3);
    check(last_code == 5, "R1 strobe code", last_code, 5);
    check(rx_pops == 3, "R7 pop count", rx_pops, 3);
    check(tx_mem[0] == 8'h11 && tx_mem[1] == 8'h22, "R5 tx data", int'({tx_mem[0], tx_mem[1]}), 16'h1122);
    check(ram_mem[5] == 8'h99 && ram_mem[6] == 8'h98, "R10 ram data", int'({ram_mem[5], ram_mem[6]}), 16'h9998);

    // R4 partial register write
    deselect();
    expect_reply(8'h16, STAT, "R4 cmd");
    expect_reply(8'hEE, 8'h56, "R4 old hi");
    deselect();
    expect_reply(8'h56, STAT, "R4 read cmd");
    expect_reply(8'h00, 8'hEE, "R4 new hi");
    expect_reply(8'h00, 8'h96, "R4 old lo kept");

    // R12 deselect mid stream and mid read
    deselect();
    expect_reply(8'h3F, STAT, "R12 rx cmd");
    expect_reply(8'h00, 8'hC3, "R12 rx data");
    deselect();
    s0 = strobe_cnt;
    expect_reply(8'h04, STAT, "R12 fresh command");
    check(strobe_cnt == s0 + 1 && last_code == 4, "R12 strobe after deselect", last_code, 4);
    check(rx_pops == 4, "R12 no pop after deselect", rx_pops, 4);
    deselect();
    expect_reply(8'h52, STAT, "R12 read cmd");
    expect_reply(8'h00, 8'h52, "R12 read hi");
    deselect();
    expect_reply(8'h06, STAT, "R12 strobe after cut read");
    check(last_code == 6, "R12 strobe code", last_code, 6);

    // R6 wrap and restart
    deselect();
    expect_reply(8'h3E, STAT, "R6 tx cmd");
    for (int k = 0; k < 130; k++) begin
      logic [7:0] g;
      send(8'(k + 16), g);
    end
    check(tx_mem[127] == 8'h8D, "R6 last slot", int'(tx_mem[127]), 8'h8D);
    check(tx_mem[0] == 8'h8E, "R6 wrap to 0", int'(tx_mem[0]), 8'h8E);
    check(tx_mem[3] == 8'h91, "R6 after wrap", int'(tx_mem[3]), 8'h91);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    deselect();
    expect_reply(8'h7E, STAT, "R5 tx cmd with read flag");
    expect_reply(8'h77, STAT, "R11 tx status");
    expect_reply(8'h78, STAT, "R11 tx status");
    check(tx_mem[0] == 8'h77, "R6 restart at 0", int'(tx_mem[0]), 8'h77);
    check(tx_mem[1] == 8'h78, "R6 continue", int'(tx_mem[1]), 8'h78);

    // R13 unpowered
    @(negedge clk); supply_ok = 1'b0;
    deselect();
    s0 = strobe_cnt;
    expect_reply(8'h14, 8'h00, "R13 cmd reply");
    expect_reply(8'h01, 8'h00, "R13 data reply");
    expect_reply(8'h02, 8'h00, "R13 data reply");
    check(reg_mem[20] == 16'hABCD, "R13 reg unchanged", int'(reg_mem[20]), 16'hABCD);
    check(strobe_cnt == s0, "R13 no strobe", strobe_cnt, s0);
    @(negedge clk); supply_ok = 1'b1;
    deselect();
    expect_reply(8'h54, STAT, "R13 readback cmd");
    expect_reply(8'h00, 8'hAB, "R13 readback hi");

    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule